// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Sequencer

This block runs one DMA channel from a chain of link descriptors kept in memory. Software loads a current-descriptor pointer and a mode word, then raises the start bit. The channel reads the descriptor at that pointer one 32-bit word per request and hands a copy job (source, destination, length) to a separate data mover. It then follows the next-link word to the next descriptor, and keeps going until it meets a descriptor whose next-link word carries the end-of-list flag.

The data mover sits outside this block. It is seen only through a level request, a pulse for each data beat, a done pulse and an error pulse. Status bits for end of chain, end of descriptor, programming error and transfer error are sticky, and software clears each one by writing a 1 to it. Each of the three interrupt classes has its own enable bit in the mode word, and the interrupt line is the OR of the enabled sticky bits. Software can stop a chain by setting the abort bit, or by dropping the start bit. The channel reports itself halted within one cycle.

Top module: `dma_link_seq`

## Requirements
- R1: After reset, busy, halted, all four sticky status bits, irq, mv_req, desc_req, cur_desc and rem_bytes are all zero.
- R2: A configuration write with cfg_sel=1 loads cur_desc with the low 5 bits forced to zero. This write is accepted only while the channel is not busy. A chain fetches the words at cur_desc+0, +4, +8 and +12, which hold the source, the destination, the next-link word and the byte count. Only the low 26 bits of the count word form the length.
- R3: For each descriptor with a non-zero length, mv_req rises with mv_src, mv_dst and mv_len taken from that descriptor. The channel then moves cur_desc to the next-link word with its low 5 bits cleared, and the jobs are issued in chain order.
- R4: When a descriptor whose next-link bit 0 is set completes, busy clears and the end-of-chain status bit sets. cur_desc keeps that descriptor's address.
- R5: A chain starts only on a 0-to-1 change of mode bit 0 (start) while the channel is idle. Rewriting start=1 while it is already 1 starts nothing.
- R6: A descriptor with length 0 issues no mover job and sets the programming-error status. The chain then carries on as usual.
- R7: rem_bytes loads the descriptor length when the count word arrives. Each mv_beat lowers it by BEAT_BYTES (8), and it saturates at 0.
- R8: An mv_err pulse sets the transfer-error status, clears busy and sets halted. cur_desc is left pointing at the failing descriptor.
- R9: If mode bit 1 (abort) is set while the channel is busy with start still set, mv_req and desc_req drop on the next cycle and busy and halted both read 1. If start is low while the channel is busy, busy clears on the next cycle with halted set. halted stays set until the next start.
- R10: A write with cfg_sel=2 clears each status bit whose write-data bit is 1: bit 0 end-of-chain, bit 1 end-of-descriptor, bit 2 programming error, bit 3 transfer error. Bits written 0 keep their value, and an event in the same cycle wins over the clear.
- R11: A write with cfg_sel=0 loads the mode word: bit 0 start, bit 1 abort, bit 2 error enable, bit 3 end-of-chain enable, bit 4 end-of-descriptor enable. irq equals (bit2 AND (PE OR TE)) OR (bit3 AND EOL) OR (bit4 AND EOT).
- R12: The end-of-descriptor status bit sets each time a descriptor completes, including one of length 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 mode, 1 descriptor pointer, 2 status clear |
| cfg_wdata | input | AW | Write data |
| desc_req | output | 1 | Descriptor word read request (level) |
| desc_addr | output | AW | Address of the requested descriptor word |
| desc_valid | input | 1 | Read data valid for the pending request |
| desc_data | input | AW | Read data |
| mv_req | output | 1 | Copy job request to the data mover (level) |
| mv_src | output | AW | Job source address |
| mv_dst | output | AW | Job destination address |
| mv_len | output | CW | Job length in bytes |
| mv_beat | input | 1 | One data beat completed |
| mv_done | input | 1 | Job finished |
| mv_err | input | 1 | Job failed |
| cur_desc | output | AW | Current descriptor pointer |
| rem_bytes | output | CW | Remaining byte count of the current job |
| busy | output | 1 | Channel active |
| halted | output | 1 | Channel stopped by software or error |
| st_eol | output | 1 | Sticky end-of-chain status |
| st_eot | output | 1 | Sticky end-of-descriptor status |
| st_pe | output | 1 | Sticky programming-error status |
| st_te | output | 1 | Sticky transfer-error status |
| irq | output | 1 | Interrupt line |

## Verification
The main walk is driven by a table of chains that differ in length (1 to 4 links), in start slot and in byte count. Together they show whether link order, next-pointer masking and the 26-bit length field are followed, and whether the beat count matches the rounded-up length. Directed cases then cover a zero-length link inside a chain, a mover error in the middle of a chain, abort and start-drop while a long job is running, and a repeated start write without a falling edge. These cases separate a halt from normal completion. The countdown sequence 20, 12, 4, 0 checks that the remaining count saturates at zero. Partial status clears and enable changes check the interrupt equation bit by bit.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FETCH = 2'd1,
        S_MOVE  = 2'd2,
        S_ABORT = 2'd3
    } eng_state_e;

    // mode word bit positions
    localparam int MB_START = 0;
    localparam int MB_ABORT = 1;
    localparam int MB_ERRIE = 2;
    localparam int MB_EOLIE = 3;
    localparam int MB_EOTIE = 4;
    localparam int MODE_W   = 5;

    // status bit positions for write-one-to-clear
    localparam int SB_EOL = 0;
    localparam int SB_EOT = 1;
    localparam int SB_PE  = 2;
    localparam int SB_TE  = 3;
    localparam int STAT_W = 4;

    localparam logic [1:0] SEL_MODE = 2'd0;
    localparam logic [1:0] SEL_CDA  = 2'd1;
    localparam logic [1:0] SEL_STAT = 2'd2;

    typedef struct packed {
        logic eol;
        logic eot;
        logic pe;
        logic te;
    } dma_evt_t;

endpackage

// File: rtl/dma_seq_regs.sv
module dma_seq_regs
    import dma_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we_i,
    input  logic [1:0]        cfg_sel_i,
    input  logic [MODE_W-1:0] cfg_wdata_i,
    input  dma_evt_t          ev_i,
    output logic              start_o,
    output logic              abort_o,
    output dma_evt_t          stk_o,
    output logic              irq_o
);

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        dma_evt_t          stk;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (cfg_we_i && cfg_sel_i == SEL_MODE) begin
            d.mode = cfg_wdata_i;
        end
        if (cfg_we_i && cfg_sel_i == SEL_STAT) begin
            if (cfg_wdata_i[SB_EOL]) d.stk.eol = 1'b0;
            if (cfg_wdata_i[SB_EOT]) d.stk.eot = 1'b0;
            if (cfg_wdata_i[SB_PE])  d.stk.pe  = 1'b0;
            if (cfg_wdata_i[SB_TE])  d.stk.te  = 1'b0;
        end
        // a new event wins over a clear in the same cycle
        d.stk.eol = d.stk.eol | ev_i.eol;
        d.stk.eot = d.stk.eot | ev_i.eot;
        d.stk.pe  = d.stk.pe  | ev_i.pe;
        d.stk.te  = d.stk.te  | ev_i.te;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign start_o = q.mode[MB_START];
    assign abort_o = q.mode[MB_ABORT];
    assign stk_o   = q.stk;
    assign irq_o   = (q.mode[MB_ERRIE] & (q.stk.pe | q.stk.te))
                   | (q.mode[MB_EOLIE] & q.stk.eol)
                   | (q.mode[MB_EOTIE] & q.stk.eot);

    // R10: a one written to the end-of-chain bit clears it unless an event arrives
    p_w1c_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we_i && cfg_sel_i == SEL_STAT && cfg_wdata_i[SB_EOL] && !ev_i.eol)
        |=> !stk_o.eol);

    // R12: a descriptor completion is always visible in the sticky bit
    p_eot_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ev_i.eot |=> stk_o.eot);

endmodule

// File: rtl/dma_seq_engine.sv
module dma_seq_engine
    import dma_seq_pkg::*;
#(
    parameter int AW         = 32,
    parameter int CW         = 26,
    parameter int BEAT_BYTES = 8
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          abort_i,
    input  logic          cda_we_i,
    input  logic [AW-1:0] cda_wdata_i,
    output logic          desc_req_o,
    output logic [AW-1:0] desc_addr_o,
    input  logic          desc_valid_i,
    input  logic [AW-1:0] desc_data_i,
    output logic          mv_req_o,
    output logic [AW-1:0] mv_src_o,
    output logic [AW-1:0] mv_dst_o,
    output logic [CW-1:0] mv_len_o,
    input  logic          mv_beat_i,
    input  logic          mv_done_i,
    input  logic          mv_err_i,
    output logic [AW-1:0] cda_o,
    output logic [CW-1:0] rem_o,
    output logic          busy_o,
    output logic          halted_o,
    output dma_evt_t      ev_o
);

    localparam int            ALIGN_BITS = 5;
    localparam logic [AW-1:0] ALIGN_MASK = ~((AW)'((1 << ALIGN_BITS) - 1));
    localparam logic [CW-1:0] BEAT_C     = (CW)'(BEAT_BYTES);

    typedef struct packed {
        eng_state_e    st;
        logic [1:0]    idx;
        logic [AW-1:0] cda;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [AW-1:0] nxt;
        logic [CW-1:0] len;
        logic [CW-1:0] rem;
        logic          halted;
        logic          start_prev;
    } eng_t;

    eng_t     q, d;
    dma_evt_t ev;
    logic     fin;
    logic     start_rise;

    assign start_rise = start_i && !q.start_prev;

    always_comb begin
        d            = q;
        ev           = '0;
        fin          = 1'b0;
        d.start_prev = start_i;

        if (cda_we_i && q.st == S_IDLE) begin
            d.cda = cda_wdata_i & ALIGN_MASK;
        end

        unique case (q.st)
            S_IDLE: begin
                if (start_rise) begin
                    d.st     = S_FETCH;
                    d.idx    = 2'd0;
                    d.halted = 1'b0;
                end
            end
            S_FETCH: begin
                if (!start_i) begin
                    d.st     = S_IDLE;
                    d.halted = 1'b1;
                end else if (abort_i) begin
                    d.st     = S_ABORT;
                    d.halted = 1'b1;
                end else if (desc_valid_i) begin
                    d.idx = q.idx + 2'd1;
                    unique case (q.idx)
                        2'd0: d.src = desc_data_i;
                        2'd1: d.dst = desc_data_i;
                        2'd2: d.nxt = desc_data_i;
                        default: begin
                            d.len = desc_data_i[CW-1:0];
                            d.rem = desc_data_i[CW-1:0];
                            if (desc_data_i[CW-1:0] == '0) begin
                                ev.pe  = 1'b1;
                                ev.eot = 1'b1;
                                fin    = 1'b1;
                            end else begin
                                d.st = S_MOVE;
                            end
                        end
                    endcase
                end
            end
            S_MOVE: begin
                if (mv_beat_i) begin
                    d.rem = (q.rem > BEAT_C) ? (q.rem - BEAT_C) : '0;
                end
                if (!start_i) begin
                    d.st     = S_IDLE;
                    d.halted = 1'b1;
                end else if (abort_i) begin
                    d.st     = S_ABORT;
                    d.halted = 1'b1;
                end else if (mv_err_i) begin
                    ev.te    = 1'b1;
                    d.st     = S_IDLE;
                    d.halted = 1'b1;
                end else if (mv_done_i) begin
                    ev.eot = 1'b1;
                    fin    = 1'b1;
                end
            end
            default: begin
                if (!start_i) begin
                    d.st = S_IDLE;
                end
            end
        endcase

        if (fin) begin
            if (q.nxt[0]) begin
                d.st   = S_IDLE;
                ev.eol = 1'b1;
            end else begin
                d.st  = S_FETCH;
                d.idx = 2'd0;
                d.cda = q.nxt & ALIGN_MASK;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    assign desc_req_o  = (q.st == S_FETCH);
    assign desc_addr_o = q.cda + {{(AW-4){1'b0}}, q.idx, 2'b00};
    assign mv_req_o    = (q.st == S_MOVE);
    assign mv_src_o    = q.src;
    assign mv_dst_o    = q.dst;
    assign mv_len_o    = q.len;
    assign cda_o       = q.cda;
    assign rem_o       = q.rem;
    assign busy_o      = (q.st != S_IDLE);
    assign halted_o    = q.halted;
    assign ev_o        = ev;

    // R9: abort with start held stops both request lines and shows halted
    p_abort_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && abort_i) |=> (!mv_req_o && !desc_req_o && busy_o && halted_o));

    // R9: dropping start while busy returns to idle in one cycle
    p_stop_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !start_i) |=> (!busy_o && halted_o));

    // R8: mover error halts and keeps the pointer on the failing link
    p_err_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_req_o && mv_err_i && start_i && !abort_i)
        |=> (halted_o && !busy_o && cda_o == $past(cda_o)));

    // R7: the remaining count never grows while a job runs
    p_rem_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mv_req_o |=> (rem_o <= $past(rem_o)));

endmodule

// File: rtl/dma_link_seq.sv
module dma_link_seq
    import dma_seq_pkg::*;
#(
    parameter int AW         = 32,
    parameter int CW         = 26,
    parameter int BEAT_BYTES = 8
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    output logic          desc_req,
    output logic [AW-1:0] desc_addr,
    input  logic          desc_valid,
    input  logic [AW-1:0] desc_data,
    output logic          mv_req,
    output logic [AW-1:0] mv_src,
    output logic [AW-1:0] mv_dst,
    output logic [CW-1:0] mv_len,
    input  logic          mv_beat,
    input  logic          mv_done,
    input  logic          mv_err,
    output logic [AW-1:0] cur_desc,
    output logic [CW-1:0] rem_bytes,
    output logic          busy,
    output logic          halted,
    output logic          st_eol,
    output logic          st_eot,
    output logic          st_pe,
    output logic          st_te,
    output logic          irq
);

    logic     start_w;
    logic     abort_w;
    dma_evt_t ev_w;
    dma_evt_t stk_w;

    dma_seq_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we_i    (cfg_we),
        .cfg_sel_i   (cfg_sel),
        .cfg_wdata_i (cfg_wdata[MODE_W-1:0]),
        .ev_i        (ev_w),
        .start_o     (start_w),
        .abort_o     (abort_w),
        .stk_o       (stk_w),
        .irq_o       (irq)
    );

    dma_seq_engine #(
        .AW         (AW),
        .CW         (CW),
        .BEAT_BYTES (BEAT_BYTES)
    ) u_eng (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_w),
        .abort_i      (abort_w),
        .cda_we_i     (cfg_we && cfg_sel == SEL_CDA),
        .cda_wdata_i  (cfg_wdata),
        .desc_req_o   (desc_req),
        .desc_addr_o  (desc_addr),
        .desc_valid_i (desc_valid),
        .desc_data_i  (desc_data),
        .mv_req_o     (mv_req),
        .mv_src_o     (mv_src),
        .mv_dst_o     (mv_dst),
        .mv_len_o     (mv_len),
        .mv_beat_i    (mv_beat),
        .mv_done_i    (mv_done),
        .mv_err_i     (mv_err),
        .cda_o        (cur_desc),
        .rem_o        (rem_bytes),
        .busy_o       (busy),
        .halted_o     (halted),
        .ev_o         (ev_w)
    );

    assign st_eol = stk_w.eol;
    assign st_eot = stk_w.eot;
    assign st_pe  = stk_w.pe;
    assign st_te  = stk_w.te;

    // R4: end-of-chain status appears together with the return to idle
    p_eol_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_eol) |-> !busy);

endmodule

// File: tb/tb_dma_link_seq.sv
module tb_dma_link_seq;

    localparam int AW = 32;
    localparam int CW = 26;
    localparam logic [31:0] ERR_SRC = 32'hDEAD_0000;
    localparam logic [31:0] M_START = 32'h01, M_ABORT = 32'h02, M_ERRIE = 32'h04,
                            M_EOLIE = 32'h08, M_EOTIE = 32'h10;

    typedef struct packed {
        logic [2:0]  nd;
        logic [2:0]  slot;
        logic [15:0] len;
        logic [15:0] beats;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{3'd1, 3'd0, 16'd64, 16'd8},
        '{3'd3, 3'd1, 16'd20, 16'd9},
        '{3'd2, 3'd4, 16'd8,  16'd2},
        '{3'd4, 3'd2, 16'd1,  16'd4}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_sel = 2'd0;
    logic [AW-1:0] cfg_wdata = '0;
    logic desc_req, desc_valid;
    logic [AW-1:0] desc_addr, desc_data;
    logic mv_req, mv_beat, mv_done, mv_err;
    logic [AW-1:0] mv_src, mv_dst, cur_desc;
    logic [CW-1:0] mv_len, rem_bytes;
    logic busy, halted, st_eol, st_eot, st_pe, st_te, irq;

    always #4 clk = ~clk;

    dma_link_seq dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .desc_req(desc_req), .desc_addr(desc_addr), .desc_valid(desc_valid), .desc_data(desc_data),
        .mv_req(mv_req), .mv_src(mv_src), .mv_dst(mv_dst), .mv_len(mv_len),
        .mv_beat(mv_beat), .mv_done(mv_done), .mv_err(mv_err),
        .cur_desc(cur_desc), .rem_bytes(rem_bytes), .busy(busy), .halted(halted),
        .st_eol(st_eol), .st_eot(st_eot), .st_pe(st_pe), .st_te(st_te), .irq(irq)
    );

    // descriptor memory: 8 slots of 32 bytes
    logic [31:0] mem [64];
    always @(posedge clk) begin
        desc_valid <= desc_req && !desc_valid;
        desc_data  <= mem[desc_addr[7:2]];
    end

    // data mover model with request log
    logic        m_active = 1'b0;
    logic [31:0] m_left = '0;
    int          log_n = 0;
    int          beat_cnt = 0;
    logic [31:0] log_src [64];
    logic [31:0] log_dst [64];
    logic [31:0] log_len [64];
    initial begin mv_done = 1'b0; mv_err = 1'b0; mv_beat = 1'b0; desc_valid = 1'b0; end
    always @(posedge clk) begin
        mv_done <= 1'b0;
        mv_err  <= 1'b0;
        mv_beat <= 1'b0;
        if (!rst_n || !mv_req) begin
            m_active <= 1'b0;
        end else if (!m_active && !mv_done && !mv_err) begin
            m_active <= 1'b1;
            m_left   <= 32'(mv_len);
            log_src[log_n[5:0]] <= mv_src;
            log_dst[log_n[5:0]] <= mv_dst;
            log_len[log_n[5:0]] <= 32'(mv_len);
            log_n <= log_n + 1;
        end else if (m_active) begin
            if (m_left > 0) begin
                mv_beat  <= 1'b1;
                m_left   <= (m_left > 8) ? m_left - 8 : 0;
                beat_cnt <= beat_cnt + 1;
            end else begin
                m_active <= 1'b0;
                if (mv_src == ERR_SRC) mv_err <= 1'b1;
                else                   mv_done <= 1'b1;
            end
        end
    end

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_desc(input int slot, input logic [31:0] s, input logic [31:0] t,
                            input logic [31:0] nx, input logic [31:0] cnt);
        mem[slot*8 + 0] = s;
        mem[slot*8 + 1] = t;
        mem[slot*8 + 2] = nx;
        mem[slot*8 + 3] = cnt;
    endtask

    task automatic go(input int slot, input logic [31:0] ies);
        cfg_write(2'd1, 32'(slot * 32));
        cfg_write(2'd0, ies | M_START);
        @(negedge clk);
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 5000) begin @(negedge clk); n++; end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int base;
        int bb;
        logic [CW-1:0] seq [8];
        int sn;
        logic [CW-1:0] last;
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1", "busy", 32'(busy), 0);
        chk("R1", "halted", 32'(halted), 0);
        chk("R1", "status", {28'd0, st_eol, st_eot, st_pe, st_te}, 0);
        chk("R1", "irq", 32'(irq), 0);
        chk("R1", "requests", {30'd0, mv_req, desc_req}, 0);
        chk("R1", "cur_desc", cur_desc, 0);
        chk("R1", "rem_bytes", 32'(rem_bytes), 0);

        // R2 pointer alignment
        cfg_write(2'd1, 32'h47);
        chk("R2", "aligned pointer", cur_desc, 32'h40);

        // R2 R3 R4 R7 R11 R12 table of chains
        for (int v = 0; v < 4; v++) begin
            base = log_n;
            bb   = beat_cnt;
            for (int i = 0; i < int'(VECS[v].nd); i++) begin
                int s;
                s = int'(VECS[v].slot) + i;
                set_desc(s, 32'h1000_0000 + 32'(s) * 32'h100, 32'h2000_0000 + 32'(s) * 32'h100,
                         (i == int'(VECS[v].nd) - 1) ? 32'h1 : 32'((s + 1) * 32) | 32'h1E,
                         32'hFC00_0000 | 32'(VECS[v].len));
            end
            go(int'(VECS[v].slot), M_EOLIE);
            wait_idle();
            chk("R3", "job count", 32'(log_n - base), 32'(VECS[v].nd));
            for (int i = 0; i < int'(VECS[v].nd); i++) begin
                int s;
                s = int'(VECS[v].slot) + i;
                chk("R3", "job src", log_src[(base + i) % 64], 32'h1000_0000 + 32'(s) * 32'h100);
                chk("R3", "job dst", log_dst[(base + i) % 64], 32'h2000_0000 + 32'(s) * 32'h100);
                chk("R2", "job len 26-bit", log_len[(base + i) % 64], 32'(VECS[v].len));
            end
            chk("R7", "beats", 32'(beat_cnt - bb), 32'(VECS[v].beats));
            chk("R7", "rem at end", 32'(rem_bytes), 0);
            chk("R4", "eol", 32'(st_eol), 1);
            chk("R12", "eot", 32'(st_eot), 1);
            chk("R4", "cur_desc last", cur_desc, 32'((int'(VECS[v].slot) + int'(VECS[v].nd) - 1) * 32));
            chk("R11", "irq eol enabled", 32'(irq), 1);
            chk("R9", "not halted", 32'(halted), 0);
            cfg_write(2'd0, M_EOLIE);
            cfg_write(2'd2, 32'hF);
            chk("R10", "all cleared", {28'd0, st_eol, st_eot, st_pe, st_te}, 0);
            chk("R11", "irq after clear", 32'(irq), 0);
        end

        // R5 start is edge triggered
        set_desc(0, 32'h3000_0000, 32'h3100_0000, 32'h1, 32'd16);
        base = log_n;
        go(0, 32'h0);
        wait_idle();
        chk("R5", "first run", 32'(log_n - base), 1);
        cfg_write(2'd0, M_START);
        repeat (20) @(negedge clk);
        chk("R5", "no restart busy", 32'(busy), 0);
        chk("R5", "no restart jobs", 32'(log_n - base), 1);
        cfg_write(2'd0, 32'h0);
        cfg_write(2'd2, 32'hF);

        // R6 R10 R11 R12 zero-length link in chain
        set_desc(5, 32'h4000_0000, 32'h4100_0000, 32'(6 * 32), 32'h0);
        set_desc(6, 32'h4200_0000, 32'h4300_0000, 32'h1, 32'd16);
        base = log_n;
        go(5, M_ERRIE | M_EOLIE);
        wait_idle();
        chk("R6", "one job only", 32'(log_n - base), 1);
        chk("R6", "job src", log_src[base % 64], 32'h4200_0000);
        chk("R6", "pe set", 32'(st_pe), 1);
        chk("R12", "eot set", 32'(st_eot), 1);
        cfg_write(2'd2, 32'h1);
        chk("R10", "eol cleared", 32'(st_eol), 0);
        chk("R10", "pe kept", 32'(st_pe), 1);
        chk("R11", "irq from pe", 32'(irq), 1);
        cfg_write(2'd2, 32'h4);
        chk("R10", "eot kept", 32'(st_eot), 1);
        chk("R11", "eot disabled irq", 32'(irq), 0);
        cfg_write(2'd0, M_EOTIE);
        chk("R11", "eot enabled irq", 32'(irq), 1);
        cfg_write(2'd2, 32'hF);
        cfg_write(2'd0, 32'h0);

        // R8 mover error in mid chain
        set_desc(0, 32'h5000_0000, 32'h5100_0000, 32'(1 * 32), 32'd16);
        set_desc(1, ERR_SRC, 32'h5300_0000, 32'(2 * 32), 32'd16);
        set_desc(2, 32'h5400_0000, 32'h5500_0000, 32'h1, 32'd16);
        base = log_n;
        go(0, M_ERRIE);
        wait_idle();
        chk("R8", "te", 32'(st_te), 1);
        chk("R8", "halted", 32'(halted), 1);
        chk("R8", "busy", 32'(busy), 0);
        chk("R8", "cur_desc on failing", cur_desc, 32'h20);
        chk("R8", "jobs issued", 32'(log_n - base), 2);
        chk("R8", "no eol", 32'(st_eol), 0);
        chk("R11", "irq on te", 32'(irq), 1);
        cfg_write(2'd0, 32'h0);
        chk("R9", "halted stays", 32'(halted), 1);
        cfg_write(2'd2, 32'hF);

        // R7 countdown with saturation
        set_desc(3, 32'h6000_0000, 32'h6100_0000, 32'h1, 32'd20);
        go(3, 32'h0);
        chk("R9", "halted cleared by start", 32'(halted), 0);
        sn = 0;
        last = rem_bytes;
        while (busy) begin
            @(negedge clk);
            if (rem_bytes != last && sn < 8) begin seq[sn] = rem_bytes; sn++; end
            last = rem_bytes;
        end
        chk("R7", "change count", 32'(sn), 4);
        chk("R7", "loaded", 32'(seq[0]), 20);
        chk("R7", "after beat 1", 32'(seq[1]), 12);
        chk("R7", "after beat 2", 32'(seq[2]), 4);
        chk("R7", "saturated", 32'(seq[3]), 0);
        cfg_write(2'd0, 32'h0);
        cfg_write(2'd2, 32'hF);

        // R9 abort during a long job
        set_desc(4, 32'h7000_0000, 32'h7100_0000, 32'h1, 32'd800);
        go(4, 32'h0);
        while (!mv_req) @(negedge clk);
        repeat (10) @(negedge clk);
        cfg_write(2'd0, M_START | M_ABORT);
        @(negedge clk);
        chk("R9", "abort drops mv_req", 32'(mv_req), 0);
        chk("R9", "abort busy", 32'(busy), 1);
        chk("R9", "abort halted", 32'(halted), 1);
        chk("R9", "abort no eot", 32'(st_eot), 0);
        cfg_write(2'd0, 32'h0);
        @(negedge clk);
        chk("R9", "idle after start low", 32'(busy), 0);
        chk("R9", "halted after abort", 32'(halted), 1);

        // R9 start dropped without abort
        go(4, 32'h0);
        while (!mv_req) @(negedge clk);
        repeat (5) @(negedge clk);
        cfg_write(2'd0, 32'h0);
        @(negedge clk);
        chk("R9", "stop busy", 32'(busy), 0);
        chk("R9", "stop halted", 32'(halted), 1);
        chk("R9", "stop mv_req", 32'(mv_req), 0);
        cfg_write(2'd2, 32'hF);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule